// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero-Bit Insertion

The block turns a stream of bytes into a serial bit-oriented frame stream. Bytes arrive over a valid/ready handshake that carries a last-byte marker. Each frame starts with a flag octet, then carries the payload least significant bit first, then a 16-bit frame check sequence, then a closing flag. When no frame is pending, the line carries back-to-back flags. A new frame may start right after the closing flag of the previous one, so one flag serves both frames.

The frame check sequence is computed over the unstuffed payload bits. Zero-bit insertion is applied afterwards, to both payload and check sequence. It is never applied to flags, so a flag is the only place where six ones in a row can appear. One output bit is produced per cycle in which the bit-clock enable is high. An optional NRZI stage, selected at run time, can recode the line.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset the line output is 1 and in_ready is 0 until the first bit_en pulse.
- R2: With no frame pending the line carries continuous flags 0x7E, bit 0 first, starting with bit 0 right after reset.
- R3: in_ready is high only in a cycle with bit_en high and only at a byte boundary. A byte transfers when in_valid and in_ready are both high.
- R4: Each frame is one opening flag, the payload bytes each sent bit 0 first, a 2-byte check field and a closing flag.
- R5: After five consecutive 1 bits in the payload or check field, one 0 bit is inserted. No run longer than six ones ever appears on the line.
- R6: Flags are never stuffed. A payload byte equal to 0x7E is recovered as data, not as a flag.
- R7: The check field is the ones-complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) over the payload bits. It is sent low byte first, each byte bit 0 first. The CRC over the payload plus the check field leaves the residue 0xF0B8.
- R8: While an inserted zero is emitted, the payload shift and the CRC are held, so no payload bit is lost or repeated.
- R9: When a new frame's first byte is valid at the end of a closing flag, that flag also opens the new frame, with no idle flag in between.
- R10: If no byte is valid at a byte boundary inside a frame, the frame ends there: the check field and closing flag follow the bytes already taken.
- R11: With nrzi_en high, a 0 bit toggles the line and a 1 bit leaves it unchanged. With nrzi_en low, the line equals the bit.
- R12: The line output changes only on the clock edge at which bit_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable that advances the line by one bit |
| nrzi_en | input | 1 | Selects NRZI coding of the line |
| in_data | input | DW | Payload byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Framer takes the byte in this cycle |
| tx_line | output | 1 | Serial line output |

## Verification
The framer is driven with a short mixed-value payload, with a payload of all ones that forces a stuffed zero every five bits, including runs that cross byte edges and reach into the check field, and with a payload made of flag-valued bytes. The recovered bytes and the check field separate lost or repeated bits from wrong stuffing. A reference unstuffer and CRC model recover every frame and check the longest run of ones. Two back-to-back frames show whether the closing flag is shared, and a payload that stops without a last marker tests the underrun close. The same frame in NRZI mode is decoded from line transitions, which tells a correct toggle rule from a plain or inverted line.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [1:0] {
      ST_FLAG = 2'd0,
      ST_DATA = 2'd1,
      ST_FCS  = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      CRC_HOLD  = 2'd0,
      CRC_INIT  = 2'd1,
      CRC_FEED  = 2'd2,
      CRC_SHIFT = 2'd3
   } crc_op_e;

endpackage

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial
   import hdlc_tx_pkg::*;
#(
   parameter int          CRC_W    = 16,
   parameter logic [15:0] CRC_POLY = 16'h8408,
   parameter logic [15:0] CRC_INIT_V = 16'hFFFF
) (
   input  logic    clk,
   input  logic    rst_n,
   input  crc_op_e op,
   input  logic    din,
   output logic    fcs_bit
);

   logic [CRC_W-1:0] crc_q;
   logic             fb;

   assign fb      = crc_q[0] ^ din;
   assign fcs_bit = ~crc_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= CRC_INIT_V[CRC_W-1:0];
      end else begin
         case (op)
            CRC_INIT:  crc_q <= CRC_INIT_V[CRC_W-1:0];
            CRC_FEED:  crc_q <= (crc_q >> 1) ^ ({CRC_W{fb}} & CRC_POLY[CRC_W-1:0]);
            CRC_SHIFT: crc_q <= crc_q >> 1;
            default:   crc_q <= crc_q;
         endcase
      end
   end

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
   import hdlc_tx_pkg::*;
#(
   parameter int          DW     = 8,
   parameter int          CRC_W  = 16,
   parameter logic [DW-1:0] FLAG_P = 'h7E,
   parameter int          RUN    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic [DW-1:0] in_data,
   input  logic          in_valid,
   input  logic          in_last,
   output logic          in_ready,
   input  logic          fcs_bit,
   output crc_op_e       crc_op,
   output logic          crc_din,
   output logic          tx_bit,
   output logic          stuffing
);

   localparam int MAXN  = (CRC_W > DW) ? CRC_W : DW;
   localparam int CNT_W = $clog2(MAXN);
   localparam int IDX_W = $clog2(DW);
   localparam int RUN_W = $clog2(RUN + 3);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DW - 1);
   localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(CRC_W - 1);
   localparam logic [RUN_W-1:0] RUN_LIM   = RUN_W'(RUN);
   localparam logic [RUN_W-1:0] OBS_SAT   = RUN_W'(RUN + 2);

   tx_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DW-1:0]    sh_q;
   logic             last_q;
   logic [RUN_W-1:0] ones_q;
   logic [RUN_W-1:0] obs_run_q;

   logic stuff_now;
   logic byte_end;
   logic fcs_end;
   logic need_byte;
   logic take;

   assign stuff_now = (ones_q == RUN_LIM);
   assign stuffing  = bit_en && stuff_now;
   assign byte_end  = (cnt_q == BYTE_LAST);
   assign fcs_end   = (cnt_q == FCS_LAST);
   assign need_byte = !stuff_now && byte_end &&
                      ((state_q == ST_FLAG) || ((state_q == ST_DATA) && !last_q));
   assign in_ready  = bit_en && need_byte;
   assign take      = in_ready && in_valid;
   assign crc_din   = sh_q[0];

   always_comb begin
      if (stuff_now) begin
         tx_bit = 1'b0;
      end else begin
         case (state_q)
            ST_DATA: tx_bit = sh_q[0];
            ST_FCS:  tx_bit = fcs_bit;
            default: tx_bit = FLAG_P[cnt_q[IDX_W-1:0]];
         endcase
      end
   end

   always_comb begin
      crc_op = CRC_HOLD;
      if (bit_en && !stuff_now) begin
         case (state_q)
            ST_FLAG: crc_op = take ? CRC_INIT : CRC_HOLD;
            ST_DATA: crc_op = CRC_FEED;
            ST_FCS:  crc_op = CRC_SHIFT;
            default: crc_op = CRC_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FLAG;
         cnt_q   <= '0;
         sh_q    <= '0;
         last_q  <= 1'b0;
         ones_q  <= '0;
      end else if (bit_en) begin
         if (stuff_now) begin
            ones_q <= '0;
         end else begin
            case (state_q)
               ST_FLAG: begin
                  if (byte_end) begin
                     cnt_q  <= '0;
                     ones_q <= '0;
                     if (take) begin
                        state_q <= ST_DATA;
                        sh_q    <= in_data;
                        last_q  <= in_last;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  ones_q <= sh_q[0] ? ones_q + 1'b1 : '0;
                  if (byte_end) begin
                     cnt_q <= '0;
                     if (take) begin
                        sh_q   <= in_data;
                        last_q <= in_last;
                     end else begin
                        state_q <= ST_FCS;
                     end
                  end else begin
                     sh_q  <= sh_q >> 1;
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_FCS: begin
                  ones_q <= fcs_bit ? ones_q + 1'b1 : '0;
                  if (fcs_end) begin
                     cnt_q   <= '0;
                     state_q <= ST_FLAG;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: begin
                  state_q <= ST_FLAG;
                  cnt_q   <= '0;
               end
            endcase
         end
      end
   end

   // Independent observer of the emitted bit stream (checking only)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_run_q <= '0;
      end else if (bit_en) begin
         if (!tx_bit)                  obs_run_q <= '0;
         else if (obs_run_q != OBS_SAT) obs_run_q <= obs_run_q + 1'b1;
      end
   end

   // R5: stuffing keeps the run counter bounded
   assert_ones_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RUN_LIM);

   // R5: no run longer than a flag's six ones reaches the line
   assert_no_long_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      obs_run_q <= RUN_W'(RUN + 1));

   // R8: payload shifter holds while an inserted zero goes out
   assert_shift_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && stuff_now && state_q == ST_DATA) |=> $stable(sh_q));

   // R3: a transfer always lands at the end of a byte slot
   assert_take_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && in_valid && in_ready) |=> (cnt_q == '0));

endmodule

// File: rtl/hdlc_line_coder.sv
module hdlc_line_coder #(
   parameter bit NRZI_SUPPORT = 1'b1,
   parameter bit IDLE_LEVEL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   input  logic nrzi_en,
   output logic line
);

   logic line_q;
   assign line = line_q;

   generate
      if (NRZI_SUPPORT) begin : g_nrzi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      line_q <= IDLE_LEVEL;
            else if (bit_en) line_q <= nrzi_en ? (bit_in ? line_q : ~line_q) : bit_in;
         end

         // R11: a zero bit in NRZI mode flips the line
         assert_nrzi_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_en && nrzi_en && !bit_in) |=> (line_q != $past(line_q)));

         // R11: a one bit in NRZI mode keeps the line
         assert_nrzi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_en && nrzi_en && bit_in) |=> $stable(line_q));
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      line_q <= IDLE_LEVEL;
            else if (bit_en) line_q <= bit_in;
         end
         logic unused_nrzi;
         assign unused_nrzi = nrzi_en;
      end
   endgenerate

   // R12: the line only moves on an enabled bit edge
   assert_line_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(line_q));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int          DW           = 8,
   parameter int          CRC_W        = 16,
   parameter logic [15:0] CRC_POLY     = 16'h8408,
   parameter logic [15:0] CRC_INIT_V   = 16'hFFFF,
   parameter logic [7:0]  FLAG_P       = 8'h7E,
   parameter int          RUN          = 5,
   parameter bit          NRZI_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          nrzi_en,
   input  logic [DW-1:0] in_data,
   input  logic          in_valid,
   input  logic          in_last,
   output logic          in_ready,
   output logic          tx_line
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("hdlc_tx_framer: DW must be 8 to match the flag octet");
      end
      if (CRC_W < 2 || CRC_W > 16) begin : g_bad_crc
         $error("hdlc_tx_framer: CRC_W must be 2..16");
      end
      if (RUN < 1 || RUN > 6) begin : g_bad_run
         $error("hdlc_tx_framer: RUN must be 1..6");
      end
   endgenerate

   crc_op_e crc_op;
   logic    crc_din;
   logic    fcs_bit;
   logic    tx_bit;
   logic    stuffing;

   hdlc_tx_seq #(
      .DW     (DW),
      .CRC_W  (CRC_W),
      .FLAG_P (FLAG_P[DW-1:0]),
      .RUN    (RUN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_last  (in_last),
      .in_ready (in_ready),
      .fcs_bit  (fcs_bit),
      .crc_op   (crc_op),
      .crc_din  (crc_din),
      .tx_bit   (tx_bit),
      .stuffing (stuffing)
   );

   hdlc_crc_serial #(
      .CRC_W      (CRC_W),
      .CRC_POLY   (CRC_POLY),
      .CRC_INIT_V (CRC_INIT_V)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (crc_op),
      .din     (crc_din),
      .fcs_bit (fcs_bit)
   );

   hdlc_line_coder #(
      .NRZI_SUPPORT (NRZI_SUPPORT),
      .IDLE_LEVEL   (1'b1)
   ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .bit_in  (tx_bit),
      .nrzi_en (nrzi_en),
      .line    (tx_line)
   );

   // R8: the CRC register does not move while an inserted zero is sent
   assert_crc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stuffing |=> $stable(fcs_bit));

   // R3: no byte is requested without a bit-clock enable
   assert_ready_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_en);

endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       nrzi_en;
   logic [7:0] in_data;
   logic       in_valid;
   logic       in_last;
   logic       in_ready;
   logic       tx_line;

   always #10 clk = ~clk;

   hdlc_tx_framer u0 (
      .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .nrzi_en (nrzi_en),
      .in_data (in_data), .in_valid (in_valid), .in_last (in_last),
      .in_ready (in_ready), .tx_line (tx_line)
   );

   int n_checks = 0;
   int n_err    = 0;

   bit   cap [0:8191];
   int   ncap = 0;
   logic prev_line;
   bit   nrzi_mode = 1'b0;

   logic [7:0] pl   [0:31];
   bit         mark [0:31];
   int         plen = 0;
   int         idx  = 0;
   bit         feeding = 1'b0;
   int         ready_bad = 0;
   int         stab_bad  = 0;

   bit         pbuf [0:2047];
   logic [7:0] fr_b [0:3][0:39];
   int         fr_len [0:3];
   int         fr_gap [0:3];
   int         nfr = 0;
   int         maxrun = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb = r[0] ^ b[k];
         r = r >> 1;
         if (fb) r = r ^ 16'h8408;
      end
      return r;
   endfunction

   task automatic step();
      bit took;
      @(negedge clk);
      bit_en = 1'b1;
      if (feeding && idx < plen) begin
         in_valid = 1'b1; in_data = pl[idx]; in_last = mark[idx];
      end else begin
         in_valid = 1'b0; in_last = 1'b0;
      end
      #1;
      took = in_valid && in_ready;
      @(negedge clk);
      bit_en = 1'b0;
      if (took) idx++;
      if (ncap < 8192) begin
         cap[ncap] = nrzi_mode ? (tx_line == prev_line) : tx_line;
         ncap++;
      end
      prev_line = tx_line;
      @(negedge clk);
      if (in_ready) ready_bad++;
      if (tx_line !== prev_line) stab_bad++;
   endtask

   task automatic parse(input int from);
      int ones = 0;
      int nb   = 0;
      int empt = 0;
      bit started = 1'b0;
      nfr = 0;
      maxrun = 0;
      for (int i = from; i < ncap; i++) begin
         if (cap[i]) begin
            ones++;
            if (ones > maxrun) maxrun = ones;
            if (nb < 2048) pbuf[nb] = 1'b1;
            nb++;
         end else if (ones == 5) begin
            ones = 0;
         end else if (ones == 6) begin
            if (started && nb > 7) begin
               int n = nb - 7;
               if (nfr < 4) begin
                  fr_len[nfr] = (n % 8 == 0) ? n / 8 : -1;
                  for (int j = 0; j < n / 8 && j < 40; j++)
                     for (int k = 0; k < 8; k++)
                        fr_b[nfr][j][k] = pbuf[8*j+k];
                  fr_gap[nfr] = empt;
                  nfr++;
               end
               empt = 0;
            end else if (started) begin
               empt++;
            end
            nb = 0; started = 1'b1; ones = 0;
         end else begin
            if (nb < 2048) pbuf[nb] = 1'b0;
            nb++;
            ones = 0;
         end
      end
   endtask

   task automatic run_frames();
      int start = ncap;
      int guard = 0;
      for (int i = 0; i < 16; i++) step();
      idx = 0; feeding = 1'b1;
      while (idx < plen && guard < 2000) begin step(); guard++; end
      feeding = 1'b0;
      for (int i = 0; i < 64; i++) step();
      check(idx == plen, "R3", "bytes accepted", idx, plen);
      parse(start);
   endtask

   task automatic check_frame(input int k, input int off, input int len, input string req);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] fcs;
      int mism = 0;
      check(fr_len[k] == len + 2, "R4", "frame length", fr_len[k], len + 2);
      for (int j = 0; j < len; j++) begin
         if (fr_b[k][j] !== pl[off+j]) mism++;
         c = crc_byte(c, pl[off+j]);
      end
      check(mism == 0, req, "payload byte mismatches", mism, 0);
      fcs = ~c;
      check({fr_b[k][len+1], fr_b[k][len]} == fcs, "R7", "check field",
            {fr_b[k][len+1], fr_b[k][len]}, fcs);
      c = crc_byte(c, fr_b[k][len]);
      c = crc_byte(c, fr_b[k][len+1]);
      check(c == 16'hF0B8, "R7", "residue", c, 16'hF0B8);
   endtask

   task automatic test_reset();
      check(tx_line === 1'b1, "R1", "line after reset", tx_line, 1);
      check(in_ready === 1'b0, "R1", "ready after reset", in_ready, 0);
   endtask

   task automatic test_idle();
      logic [7:0] fp = 8'h7E;
      int bad = 0;
      for (int i = 0; i < 32; i++) step();
      for (int i = 0; i < 32; i++) if (cap[i] != fp[i % 8]) bad++;
      check(bad == 0, "R2", "idle flag bit mismatches", bad, 0);
   endtask

   task automatic test_mixed();
      pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'hA5; pl[3] = 8'h0F;
      for (int i = 0; i < 4; i++) mark[i] = (i == 3);
      plen = 4;
      run_frames();
      check(nfr == 1, "R4", "frames found", nfr, 1);
      check_frame(0, 0, 4, "R4");
   endtask

   task automatic test_all_ones();
      for (int i = 0; i < 5; i++) begin pl[i] = 8'hFF; mark[i] = (i == 4); end
      plen = 5;
      run_frames();
      check(nfr == 1, "R5", "frames found", nfr, 1);
      check(maxrun <= 6, "R5", "longest run of ones", maxrun, 6);
      check_frame(0, 0, 5, "R8");
   endtask

   task automatic test_flag_bytes();
      for (int i = 0; i < 3; i++) begin pl[i] = 8'h7E; mark[i] = (i == 2); end
      plen = 3;
      run_frames();
      check(nfr == 1, "R6", "frames found", nfr, 1);
      check(maxrun == 6, "R6", "longest run (flags only)", maxrun, 6);
      check_frame(0, 0, 3, "R6");
   endtask

   task automatic test_back_to_back();
      pl[0] = 8'hC3; pl[1] = 8'h81; pl[2] = 8'h3C; pl[3] = 8'h55; pl[4] = 8'hF8;
      for (int i = 0; i < 5; i++) mark[i] = (i == 1) || (i == 4);
      plen = 5;
      run_frames();
      check(nfr == 2, "R9", "frames found", nfr, 2);
      check(fr_gap[1] == 0, "R9", "idle flags between frames", fr_gap[1], 0);
      check_frame(0, 0, 2, "R9");
      check_frame(1, 2, 3, "R9");
   endtask

   task automatic test_underrun();
      pl[0] = 8'h01; pl[1] = 8'hE7; pl[2] = 8'h3E;
      for (int i = 0; i < 3; i++) mark[i] = 1'b0;
      plen = 3;
      run_frames();
      check(nfr == 1, "R10", "frames found", nfr, 1);
      check_frame(0, 0, 3, "R10");
   endtask

   task automatic test_nrzi();
      @(negedge clk);
      nrzi_en = 1'b1; nrzi_mode = 1'b1;
      pl[0] = 8'h00; pl[1] = 8'hFF; pl[2] = 8'h6B;
      for (int i = 0; i < 3; i++) mark[i] = (i == 2);
      plen = 3;
      run_frames();
      check(nfr == 1, "R11", "frames found under NRZI", nfr, 1);
      check_frame(0, 0, 3, "R11");
      nrzi_en = 1'b0; nrzi_mode = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bit_en = 1'b0; nrzi_en = 1'b0;
      in_data = '0; in_valid = 1'b0; in_last = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      prev_line = tx_line;
      test_reset();
      test_idle();
      test_mixed();
      test_all_ones();
      test_flag_bytes();
      test_back_to_back();
      test_underrun();
      test_nrzi();
      check(ready_bad == 0, "R3", "ready without bit_en", ready_bad, 0);
      check(stab_bad == 0, "R12", "line moved without bit_en", stab_bad, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule